// File: doc/BRIEF.md
# Dual-Clock Fall-Through Command Queue

This block moves memory access commands from a user clock domain into the clock domain of a memory controller. Each command consists of a burst length, a word address and a small opcode. The writer presents all three fields together with a write strobe. The block stores them as one 40-bit entry in a 64-deep queue, and the entry comes out in the other domain split back into the same three fields.

The read side works in fall-through mode. Whenever the queue is not empty, the oldest command is already on the read outputs, so the controller can decode it before it decides to take it. A pop strobe only discards the head entry, and the next entry shows on the following read-clock cycle.

The two pointers cross the clock boundary as Gray codes through two-stage synchronisers. The write side derives full and the read side derives empty and an occupancy count. Both flags are pessimistic while a pointer update is still in flight. The whole queue is held in reset when the controller's reset is active or when memory calibration has not finished.

Top module: `cmdq_cdc_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0 and the fill count is 0.
- R2: The queue is held cleared while ctrlRst is 1 or calDone is 0. Entries written before such a reset are gone afterwards: empty returns to 1 and the count to 0.
- R3: A command comes out with the same burst length, address and opcode it was written with. Inside the stored entry the burst length is bits [39:32], the address [31:3] and the opcode [2:0].
- R4: While empty is 0, the head entry is present on the read field outputs with no pop needed. A pop at a read-clock edge presents the next entry in the cycle after that edge.
- R5: Commands leave the queue in the order they were accepted, with none lost or duplicated, even when writes and pops run at the same time.
- R6: After a write into an empty queue, empty stays 1 through the first read-clock edge that follows the write, and it is 0 after the third read-clock edge.
- R7: full rises in the write-clock cycle after the 64th unread entry is stored. A write while full is 1 is dropped and never reaches the read side.
- R8: A pop while empty is 1 has no effect. Empty stays 1, the count stays 0, and the next command written is read back correctly.
- R9: Once the pointers have settled, the fill count on the read side equals the number of stored entries, from 0 up to 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | User-side clock for writes |
| rdClk | input | 1 | Controller-side clock for reads |
| ctrlRst | input | 1 | Controller reset, active high |
| calDone | input | 1 | Memory calibration finished; low holds the queue in reset |
| wrEn | input | 1 | Write strobe for one command |
| wrBurst | input | 8 | Burst length of the command being written |
| wrAddr | input | 29 | Word address of the command being written |
| wrOp | input | 3 | Opcode of the command being written |
| full | output | 1 | Queue full, write domain |
| rdPop | input | 1 | Discard the head command |
| rdBurst | output | 8 | Burst length of the head command |
| rdAddr | output | 29 | Address of the head command |
| rdOp | output | 3 | Opcode of the head command |
| empty | output | 1 | No command available, read domain |
| rdCount | output | 7 | Entries held, read domain |

## Verification
A write and a pop can fall on the same stretch of time. At that moment both pointers move, and each synchroniser carries a Gray code that is changing. The bench provokes this by streaming 100 commands back to back while a monitor in the read domain pops every head entry as soon as empty is 0. The read clock runs at a period unrelated to the write clock, so the phases between the two edges keep shifting. Each popped entry is judged against the next item of a scoreboard queue filled by the write driver, and at the end the count of popped entries and the final empty and count values are checked as well.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
package cmdq_pkg;
  localparam int BURST_W  = 8;
  localparam int ADDR_W   = 29;
  localparam int OP_W     = 3;
  localparam int ENTRY_W  = BURST_W + ADDR_W + OP_W;
  localparam int OP_LO    = 0;
  localparam int ADDR_LO  = OP_W;
  localparam int BURST_LO = OP_W + ADDR_W;
  localparam int IDX_W    = 6;
  localparam int PTR_W    = IDX_W + 1;
  localparam int DEPTH    = 1 << IDX_W;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic             push;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
  } qStrobe_t;

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/cmdq_sync.sv
`timescale 1ns/1ps
module cmdq_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or posedge rst) begin
        if (rst)         chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else             chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmdq_ctrl.sv
`timescale 1ns/1ps
module cmdq_ctrl
  import cmdq_pkg::*;
(
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstAny,
  input  logic             wrEn,
  input  logic             rdPop,
  output logic             full,
  output logic             empty,
  output logic [PTR_W-1:0] rdCount,
  output qStrobe_t         strb
);
  logic [PTR_W-1:0] wrBin, wrGray, wrBinNxt;
  logic [PTR_W-1:0] rdBin, rdGray, rdBinNxt;
  logic [PTR_W-1:0] rqSync, wqSync;
  logic             pushOk, popOk;

  // write domain: pointer and pessimistic full
  assign pushOk   = wrEn & ~full;
  assign wrBinNxt = wrBin + {{(PTR_W-1){1'b0}}, pushOk};

  always_ff @(posedge wrClk or posedge rstAny) begin
    if (rstAny) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else begin
      wrBin  <= wrBinNxt;
      wrGray <= toGray(wrBinNxt);
    end
  end

  cmdq_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) rdPtrToWr (
    .clk(wrClk), .rst(rstAny), .d(rdGray), .q(rqSync)
  );

  assign full = (wrGray == {~rqSync[PTR_W-1:PTR_W-2], rqSync[PTR_W-3:0]});

  // read domain: pointer, pessimistic empty, occupancy
  assign popOk    = rdPop & ~empty;
  assign rdBinNxt = rdBin + {{(PTR_W-1){1'b0}}, popOk};

  always_ff @(posedge rdClk or posedge rstAny) begin
    if (rstAny) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else begin
      rdBin  <= rdBinNxt;
      rdGray <= toGray(rdBinNxt);
    end
  end

  cmdq_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) wrPtrToRd (
    .clk(rdClk), .rst(rstAny), .d(wrGray), .q(wqSync)
  );

  assign empty   = (rdGray == wqSync);
  assign rdCount = fromGray(wqSync) - rdBin;

  assign strb.push  = pushOk;
  assign strb.wrIdx = wrBin[IDX_W-1:0];
  assign strb.rdIdx = rdBin[IDX_W-1:0];

  // R7: a blocked write leaves the write pointer alone
  a_r7_no_overflow: assert property (@(posedge wrClk) disable iff (rstAny)
    (wrEn && full) |=> $stable(wrBin));

  // R8: a pop on an empty queue leaves the read pointer alone
  a_r8_no_underflow: assert property (@(posedge rdClk) disable iff (rstAny)
    (rdPop && empty) |=> $stable(rdBin));

  // R4: an accepted pop advances the head by exactly one
  a_r4_pop_step: assert property (@(posedge rdClk) disable iff (rstAny)
    (rdPop && !empty) |=> (rdBin == $past(rdBin) + 1'b1));

  // R5: pointers cross the boundary changing one bit at a time
  a_r5_wr_gray_step: assert property (@(posedge wrClk) disable iff (rstAny)
    1'b1 |=> ($countones(wrGray ^ $past(wrGray)) <= 1));
  a_r5_rd_gray_step: assert property (@(posedge rdClk) disable iff (rstAny)
    1'b1 |=> ($countones(rdGray ^ $past(rdGray)) <= 1));

  // R9: occupancy never exceeds the depth
  a_r9_count_bound: assert property (@(posedge rdClk) disable iff (rstAny)
    rdCount <= PTR_W'(DEPTH));
endmodule

// File: rtl/cmdq_data.sv
`timescale 1ns/1ps
module cmdq_data
  import cmdq_pkg::*;
(
  input  logic               wrClk,
  input  logic               wrEn,
  input  logic [BURST_W-1:0] wrBurst,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [OP_W-1:0]    wrOp,
  input  qStrobe_t           strb,
  output logic [BURST_W-1:0] rdBurst,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [OP_W-1:0]    rdOp
);
  logic [ENTRY_W-1:0] store [DEPTH];
  logic [ENTRY_W-1:0] packedIn, headWord;

  // idle strobe presents an all-zero word
  assign packedIn = wrEn ? {wrBurst, wrAddr, wrOp} : '0;

  always_ff @(posedge wrClk) begin
    if (strb.push) store[strb.wrIdx] <= packedIn;
  end

  // fall-through: the head slot is read without a clock
  assign headWord = store[strb.rdIdx];
  assign rdBurst  = headWord[BURST_LO +: BURST_W];
  assign rdAddr   = headWord[ADDR_LO  +: ADDR_W];
  assign rdOp     = headWord[OP_LO    +: OP_W];
endmodule

// File: rtl/cmdq_cdc_fifo.sv
`timescale 1ns/1ps
module cmdq_cdc_fifo
  import cmdq_pkg::*;
(
  input  logic               wrClk,
  input  logic               rdClk,
  input  logic               ctrlRst,
  input  logic               calDone,
  input  logic               wrEn,
  input  logic [BURST_W-1:0] wrBurst,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [OP_W-1:0]    wrOp,
  output logic               full,
  input  logic               rdPop,
  output logic [BURST_W-1:0] rdBurst,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [OP_W-1:0]    rdOp,
  output logic               empty,
  output logic [PTR_W-1:0]   rdCount
);
  logic     rstAny;
  qStrobe_t strb;

  assign rstAny = ctrlRst | ~calDone;

  cmdq_ctrl ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstAny(rstAny),
    .wrEn(wrEn), .rdPop(rdPop),
    .full(full), .empty(empty), .rdCount(rdCount), .strb(strb)
  );

  cmdq_data data_i (
    .wrClk(wrClk), .wrEn(wrEn),
    .wrBurst(wrBurst), .wrAddr(wrAddr), .wrOp(wrOp),
    .strb(strb),
    .rdBurst(rdBurst), .rdAddr(rdAddr), .rdOp(rdOp)
  );
endmodule

// File: tb/cmdq_cdc_fifo_tb_top.sv
`timescale 1ns/1ps
module cmdq_cdc_fifo_tb_top;
  logic        wrClk = 1'b0, rdClk = 1'b0;
  logic        ctrlRst = 1'b1, calDone = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrBurst = '0;
  logic [28:0] wrAddr = '0;
  logic [2:0]  wrOp = '0;
  logic        full, empty;
  logic        rdPop;
  logic [7:0]  rdBurst;
  logic [28:0] rdAddr;
  logic [2:0]  rdOp;
  logic [6:0]  rdCount;

  logic        monOn = 1'b0, monPop = 1'b0, manPop = 1'b0;
  int          total = 0, bad = 0, popped = 0;
  bit          finished = 0;
  logic [39:0] exp[$];

  assign rdPop = monPop | manPop;

  always #10 wrClk = ~wrClk;            // 50 MHz
  initial begin #3; forever #7 rdClk = ~rdClk; end

  cmdq_cdc_fifo dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .ctrlRst(ctrlRst), .calDone(calDone),
    .wrEn(wrEn), .wrBurst(wrBurst), .wrAddr(wrAddr), .wrOp(wrOp), .full(full),
    .rdPop(rdPop), .rdBurst(rdBurst), .rdAddr(rdAddr), .rdOp(rdOp),
    .empty(empty), .rdCount(rdCount)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [39:0] mk(input int i);
    return {8'(i * 3 + 1), 29'(i * 40503 + 17), 3'(i)};
  endfunction

  // driver: presents a command, records it if it will be accepted
  task automatic pushEntry(input logic [39:0] e, input bit retry);
    bit done = 0;
    while (!done) begin
      @(negedge wrClk);
      wrEn = 1'b1;
      {wrBurst, wrAddr, wrOp} = e;
      if (!full) begin exp.push_back(e); done = 1; end
      else if (!retry) done = 1;
    end
  endtask

  task automatic wrIdle();
    @(posedge wrClk); #1 wrEn = 1'b0;
  endtask

  task automatic rdWait(input int n);
    repeat (n) @(posedge rdClk);
    @(negedge rdClk);
  endtask

  task automatic manualPop();
    @(negedge rdClk); manPop = 1'b1;
    @(negedge rdClk); manPop = 1'b0;
  endtask

  task automatic waitDrain();
    for (int i = 0; i < 3000 && !(exp.size() == 0 && empty); i++) @(negedge rdClk);
    rdWait(1);
  endtask

  // monitor: compares each head entry with the scoreboard, then pops it
  initial forever begin
    @(negedge rdClk);
    if (monOn && !empty) begin
      if (exp.size() == 0) check(1'b0, "R5 unexpected entry", {rdBurst, rdAddr, rdOp}, 0);
      else begin
        logic [39:0] e;
        e = exp.pop_front();
        check({rdBurst, rdAddr, rdOp} == e, "R5/R3 order and fields", {rdBurst, rdAddr, rdOp}, e);
      end
      popped++;
      monPop = 1'b1;
    end else monPop = 1'b0;
  end

  initial begin
    #3000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [39:0] a, b, c;
    a = {8'hA5, 29'h1ABCDEF5, 3'd6};
    b = {8'h3C, 29'h00F0F00A, 3'd1};
    c = {8'hFF, 29'h1FFFFFFF, 3'd7};
    repeat (4) @(posedge wrClk);
    #1 calDone = 1'b1;
    repeat (2) @(posedge wrClk);
    #1 ctrlRst = 1'b0;
    rdWait(2);
    check(empty == 1'b1, "R1 empty", empty, 1);
    check(full == 1'b0, "R1 full", full, 0);
    check(rdCount == 0, "R1 count", rdCount, 0);

    // R6 latency and R3 field packing
    pushEntry(a, 1'b1);
    wrIdle();
    @(posedge rdClk); @(negedge rdClk);
    check(empty == 1'b1, "R6 empty still high after first read edge", empty, 1);
    rdWait(2);
    check(empty == 1'b0, "R6 empty low by third read edge", empty, 0);
    check({rdBurst, rdAddr, rdOp} == a, "R3 fields", {rdBurst, rdAddr, rdOp}, a);

    // R4 fall-through head, pop advances next cycle
    pushEntry(b, 1'b1);
    wrIdle();
    rdWait(5);
    check({rdBurst, rdAddr, rdOp} == a, "R4 head visible without pop", {rdBurst, rdAddr, rdOp}, a);
    check(rdCount == 2, "R9 count two", rdCount, 2);
    manualPop();
    check({rdBurst, rdAddr, rdOp} == b, "R4 next entry after pop", {rdBurst, rdAddr, rdOp}, b);
    check(rdCount == 1, "R9 count one", rdCount, 1);
    manualPop();
    check(empty == 1'b1, "R4 empty after last pop", empty, 1);
    exp.delete();

    // R8 pops on empty are ignored
    @(negedge rdClk); manPop = 1'b1;
    repeat (5) @(negedge rdClk);
    manPop = 1'b0;
    check(empty == 1'b1, "R8 empty stays high", empty, 1);
    check(rdCount == 0, "R8 count stays zero", rdCount, 0);
    pushEntry(c, 1'b1);
    wrIdle();
    rdWait(5);
    check(rdCount == 1, "R8 count after later write", rdCount, 1);
    check({rdBurst, rdAddr, rdOp} == c, "R8 later entry intact", {rdBurst, rdAddr, rdOp}, c);
    manualPop();
    exp.delete();
    rdWait(3);

    // R7 fill to full, extra write dropped
    for (int i = 0; i < 64; i++) pushEntry(mk(i), 1'b1);
    wrIdle();
    @(negedge wrClk);
    check(full == 1'b1, "R7 full after 64 entries", full, 1);
    pushEntry(mk(999), 1'b0);
    wrIdle();
    check(exp.size() == 64, "R7 blocked write not recorded", exp.size(), 64);
    rdWait(5);
    check(rdCount == 64, "R9 count at depth", rdCount, 64);
    popped = 0;
    monOn = 1'b1;
    waitDrain();
    monOn = 1'b0;
    check(popped == 64, "R7 only 64 entries come out", popped, 64);
    repeat (4) @(negedge wrClk);
    check(full == 1'b0, "R7 full released after drain", full, 0);

    // R5 concurrent writes and pops
    popped = 0;
    monOn = 1'b1;
    for (int i = 100; i < 200; i++) pushEntry(mk(i), 1'b1);
    wrIdle();
    waitDrain();
    monOn = 1'b0;
    check(popped == 100, "R5 all streamed entries popped", popped, 100);
    check(empty == 1'b1 && rdCount == 0, "R5 empty after stream", {empty, rdCount}, {1'b1, 7'd0});

    // R2 calibration low clears the queue
    for (int i = 0; i < 3; i++) pushEntry(mk(i + 300), 1'b1);
    wrIdle();
    rdWait(5);
    check(rdCount == 3, "R9 count three", rdCount, 3);
    #1 calDone = 1'b0;
    rdWait(3);
    check(empty == 1'b1 && rdCount == 0, "R2 cleared by calibration low", {empty, rdCount}, {1'b1, 7'd0});
    #1 calDone = 1'b1;
    exp.delete();
    rdWait(2);
    check(empty == 1'b1, "R2 still empty after release", empty, 1);

    // R2 controller reset clears the queue
    pushEntry(mk(400), 1'b1);
    wrIdle();
    rdWait(5);
    check(empty == 1'b0, "R2 entry present before reset", empty, 0);
    #1 ctrlRst = 1'b1;
    rdWait(2);
    #1 ctrlRst = 1'b0;
    exp.delete();
    rdWait(3);
    check(empty == 1'b1 && rdCount == 0 && full == 1'b0, "R2 cleared by controller reset",
          {full, empty, rdCount}, {1'b0, 1'b1, 7'd0});

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule